// File: doc/BRIEF.md
# Write State Buffer

This block records, for each locally modified shared cache line, which words of that line have been written since the line was last pushed out. It keeps only the line address, a per-word dirty mask and an ownership flag. The modified data itself stays in the cache. The coherence controller uses the recorded masks to build update or write-back messages. The processor uses the block's stall output to decide when it must wait.

Two policies are chosen by a mode input. In update mode, dirty masks are sent out as soon as more entries are occupied than a threshold allows, and all of them are sent at a release. In invalidate mode, an entry may retire only after ownership of its line has been granted. The processor keeps running meanwhile, unless the buffer is full or a release is still waiting on entries. Entries leave strictly oldest first, over a valid/ready handshake. A word-level lookup tells the cache whether a read hits a word that is still marked dirty, so that read can be served locally.

Top module: `wsb_tracker`

## Requirements
- R1: The buffer holds at most ENTRIES (default 8) lines. While it is full, a store to a line not already tracked is not taken: the line does not become dirty in the lookup.
- R2: A store to an untracked line allocates a new entry. The new entry's mask has only bit `st_word` set, where bit i stands for word i of the line.
- R3: A store to a line that is already tracked sets bit `st_word` in that entry's mask, keeps the bits already set, and takes no new entry. This holds even while the buffer is full.
- R4: With `upd_mode`=1 and no release pending, `fl_valid` is high exactly when more than THRESH (default 4) entries are occupied.
- R5: With `upd_mode`=0, the oldest entry is offered on `fl_valid` only once a grant (`grant_valid` with a matching `grant_line`) has reached it. The grant may arrive in the same cycle as the store that allocates the entry.
- R6: `stall` is high while the buffer is full, or while a release is pending and any entry remains.
- R7: `rd_dirty` is high in the same cycle exactly when `rd_line` is tracked and bit `rd_word` of its mask is set.
- R8: A `rel_req` pulse makes the buffer drain every entry. In update mode this ignores the threshold; in invalidate mode each entry still waits for its grant. `rel_done` then pulses high for exactly one cycle once the buffer is empty. This also happens at once if the buffer was already empty.
- R9: `fl_line`/`fl_mask` always show the oldest entry. While `fl_valid` is held without `fl_ready`, `fl_line` does not change. The entry is freed at the clock edge where `fl_valid` and `fl_ready` are both high.
- R10: When a flush is accepted and a new line is allocated in the same cycle, occupancy stays unchanged and both lines are accounted for. A store to the very line being flushed in that cycle opens a fresh entry for that line.
- R11: In update mode, with THRESH or fewer entries and no release pending, no flush is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_mode | input | 1 | 1 = write-update policy, 0 = write-invalidate policy |
| st_valid | input | 1 | A store to a shared line occurs this cycle |
| st_line | input | LINE_W | Line address of the store |
| st_word | input | $clog2(WORDS) | Word index within the line |
| rel_req | input | 1 | Release point reached (one-cycle pulse) |
| grant_valid | input | 1 | Ownership grant arrives this cycle |
| grant_line | input | LINE_W | Line address the grant refers to |
| fl_valid | output | 1 | Oldest entry is offered for flushing |
| fl_ready | input | 1 | Outgoing message path accepts the offered entry |
| fl_line | output | LINE_W | Line address of the oldest entry |
| fl_mask | output | WORDS | Dirty-word mask of the oldest entry |
| stall | output | 1 | Processor must hold its next memory operation |
| rd_line | input | LINE_W | Line address of a read lookup |
| rd_word | input | $clog2(WORDS) | Word index of a read lookup |
| rd_dirty | output | 1 | Looked-up word is dirty in the buffer |
| rel_done | output | 1 | One-cycle pulse: release has fully drained |

## Verification
Two functions can meet at one clock edge: a flush handshake completing and a store allocating a new entry. The bench provokes this by raising `fl_ready` and `st_valid` together while five entries are held in update mode. It does so once for an unrelated line and once for the very line at the head. In both cases it judges the result only at the ports. Occupancy must stay above the threshold, so `fl_valid` stays high. The next-oldest line must appear on `fl_line`. The lookup must report the newly stored word as dirty.

// File: rtl/wsb_pkg.sv
package wsb_pkg;

    typedef enum logic {
        POL_INVAL  = 1'b0,
        POL_UPDATE = 1'b1
    } wsb_pol_e;

    // Whether the oldest entry may be offered for flushing.
    function automatic logic wsb_flush_ok(
        input wsb_pol_e pol,
        input logic     head_owned,
        input logic     over_thresh,
        input logic     rel_pending
    );
        if (pol == POL_UPDATE) begin
            return over_thresh || rel_pending;
        end
        return head_owned;
    endfunction

endpackage

// File: rtl/wsb_lookup.sv
module wsb_lookup #(
    parameter int N      = 8,
    parameter int LINE_W = 26
) (
    input  logic [N-1:0][LINE_W-1:0] lines,
    input  logic [N-1:0]             valid,
    input  logic [LINE_W-1:0]        key,
    output logic [N-1:0]             hit
);
    for (genvar gi = 0; gi < N; gi++) begin : g_cmp
        assign hit[gi] = valid[gi] && (lines[gi] == key);
    end
endmodule

// File: rtl/wsb_policy.sv
module wsb_policy
    import wsb_pkg::*;
#(
    parameter int N      = 8,
    parameter int THRESH = 4,
    localparam int CNT_W = $clog2(N + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  wsb_pol_e         pol,
    input  logic [CNT_W-1:0] count,
    input  logic             head_owned,
    input  logic             rel_req,
    output logic             fl_valid,
    output logic             stall,
    output logic             rel_done
);
    logic rel_pend;
    logic full;
    logic empty;

    assign full     = (count == CNT_W'(N));
    assign empty    = (count == '0);
    assign rel_done = rel_pend && empty;
    assign stall    = full || (rel_pend && !empty);
    assign fl_valid = !empty &&
                      wsb_flush_ok(pol, head_owned, count > CNT_W'(THRESH), rel_pend);

    always_ff @(posedge clk) begin
        if (rst) begin
            rel_pend <= 1'b0;
        end else if (rel_done) begin
            rel_pend <= 1'b0;
        end else if (rel_req) begin
            rel_pend <= 1'b1;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rel_done |=> !rel_done); // R8

endmodule

// File: rtl/wsb_tracker.sv
module wsb_tracker
    import wsb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int WORDS   = 8,
    parameter int LINE_W  = 26,
    parameter int THRESH  = 4,
    localparam int WIDX_W = $clog2(WORDS),
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_mode,
    input  logic              st_valid,
    input  logic [LINE_W-1:0] st_line,
    input  logic [WIDX_W-1:0] st_word,
    input  logic              rel_req,
    input  logic              grant_valid,
    input  logic [LINE_W-1:0] grant_line,
    output logic              fl_valid,
    input  logic              fl_ready,
    output logic [LINE_W-1:0] fl_line,
    output logic [WORDS-1:0]  fl_mask,
    output logic              stall,
    input  logic [LINE_W-1:0] rd_line,
    input  logic [WIDX_W-1:0] rd_word,
    output logic              rd_dirty,
    output logic              rel_done
);
    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [WORDS-1:0]  mask;
        logic              owned;
    } ent_t;

    // Entry 0 is always the oldest; the queue compacts on every flush.
    ent_t [ENTRIES-1:0] q;
    ent_t [ENTRIES-1:0] s_q;
    ent_t [ENTRIES-1:0] n_q;
    logic [CNT_W-1:0]   count;
    logic [CNT_W-1:0]   s_count;

    logic [ENTRIES-1:0][LINE_W-1:0] cur_lines;
    logic [ENTRIES-1:0][LINE_W-1:0] s_lines;
    logic [ENTRIES-1:0]             cur_valid;
    logic [ENTRIES-1:0]             s_valid;
    logic [ENTRIES-1:0]             rd_bits;
    logic [ENTRIES-1:0]             st_hit;
    logic [ENTRIES-1:0]             gr_hit;
    logic [ENTRIES-1:0]             rd_hit;

    logic             pop;
    logic             alloc;
    logic             merge;
    logic [WORDS-1:0] wbit;
    wsb_pol_e         pol;

    assign pol     = wsb_pol_e'(upd_mode);
    assign pop     = fl_valid && fl_ready;
    assign s_count = count - CNT_W'(pop);
    assign wbit    = WORDS'(1) << st_word;

    // View of the queue after this cycle's flush, used for merging and grants.
    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_slot
        if (gi < ENTRIES - 1) begin : g_mid
            assign s_q[gi] = pop ? q[gi+1] : q[gi];
        end else begin : g_last
            assign s_q[gi] = pop ? '0 : q[gi];
        end
        assign cur_valid[gi] = CNT_W'(gi) < count;
        assign s_valid[gi]   = CNT_W'(gi) < s_count;
        assign cur_lines[gi] = q[gi].line;
        assign s_lines[gi]   = s_q[gi].line;
        assign rd_bits[gi]   = q[gi].mask[rd_word];
    end

    wsb_lookup #(.N(ENTRIES), .LINE_W(LINE_W)) u_st_look (
        .lines(s_lines), .valid(s_valid), .key(st_line), .hit(st_hit)
    );

    wsb_lookup #(.N(ENTRIES), .LINE_W(LINE_W)) u_gr_look (
        .lines(s_lines), .valid(s_valid), .key(grant_line), .hit(gr_hit)
    );

    wsb_lookup #(.N(ENTRIES), .LINE_W(LINE_W)) u_rd_look (
        .lines(cur_lines), .valid(cur_valid), .key(rd_line), .hit(rd_hit)
    );

    assign merge = st_valid && (|st_hit);
    assign alloc = st_valid && !(|st_hit) && (s_count < CNT_W'(ENTRIES));

    always_comb begin
        n_q = s_q;
        for (int i = 0; i < ENTRIES; i++) begin
            if (merge && st_hit[i]) begin
                n_q[i].mask = s_q[i].mask | wbit;
            end
            if (grant_valid && gr_hit[i]) begin
                n_q[i].owned = 1'b1;
            end
            if (alloc && (s_count == CNT_W'(i))) begin
                n_q[i].line  = st_line;
                n_q[i].mask  = wbit;
                n_q[i].owned = grant_valid && (grant_line == st_line);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            count <= '0;
        end else begin
            q     <= n_q;
            count <= s_count + CNT_W'(alloc);
        end
    end

    wsb_policy #(.N(ENTRIES), .THRESH(THRESH)) u_policy (
        .clk       (clk),
        .rst       (rst),
        .pol       (pol),
        .count     (count),
        .head_owned(q[0].owned),
        .rel_req   (rel_req),
        .fl_valid  (fl_valid),
        .stall     (stall),
        .rel_done  (rel_done)
    );

    assign fl_line  = q[0].line;
    assign fl_mask  = q[0].mask;
    assign rd_dirty = |(rd_hit & rd_bits);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(ENTRIES)); // R1
    AST_ALLOC_GROWS: assert property (@(posedge clk) disable iff (rst)
        (alloc && !pop) |=> count == $past(count) + 1'b1); // R2
    AST_MERGE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (merge && !pop) |=> count == $past(count)); // R3
    AST_POP_FREES: assert property (@(posedge clk) disable iff (rst)
        (pop && !alloc) |=> count == $past(count) - 1'b1); // R9
    AST_SWAP_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (pop && alloc) |=> count == $past(count)); // R10
    AST_INV_OWNED: assert property (@(posedge clk) disable iff (rst)
        (pop && !upd_mode) |-> q[0].owned); // R5
    AST_UPD_THRESH: assert property (@(posedge clk) disable iff (rst)
        (upd_mode && count > CNT_W'(THRESH)) |-> fl_valid); // R4
    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fl_valid && !fl_ready) |=> $stable(fl_line)); // R9

endmodule

// File: tb/wsb_tracker_bench.sv
module wsb_tracker_bench;
    localparam int LINE_W = 26;
    localparam int WORDS  = 8;
    localparam int WIDX_W = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              upd_mode = 1'b1;
    logic              st_valid = 1'b0;
    logic [LINE_W-1:0] st_line = '0;
    logic [WIDX_W-1:0] st_word = '0;
    logic              rel_req = 1'b0;
    logic              grant_valid = 1'b0;
    logic [LINE_W-1:0] grant_line = '0;
    logic              fl_valid;
    logic              fl_ready = 1'b0;
    logic [LINE_W-1:0] fl_line;
    logic [WORDS-1:0]  fl_mask;
    logic              stall;
    logic [LINE_W-1:0] rd_line = '0;
    logic [WIDX_W-1:0] rd_word = '0;
    logic              rd_dirty;
    logic              rel_done;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    wsb_tracker u_wsb_tracker (
        .clk(clk), .rst(rst), .upd_mode(upd_mode),
        .st_valid(st_valid), .st_line(st_line), .st_word(st_word),
        .rel_req(rel_req), .grant_valid(grant_valid), .grant_line(grant_line),
        .fl_valid(fl_valid), .fl_ready(fl_ready), .fl_line(fl_line), .fl_mask(fl_mask),
        .stall(stall), .rd_line(rd_line), .rd_word(rd_word), .rd_dirty(rd_dirty),
        .rel_done(rel_done)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic store(input logic [LINE_W-1:0] l, input logic [WIDX_W-1:0] w);
        st_valid = 1'b1; st_line = l; st_word = w;
        tick();
        st_valid = 1'b0;
    endtask

    task automatic grant(input logic [LINE_W-1:0] l);
        grant_valid = 1'b1; grant_line = l;
        tick();
        grant_valid = 1'b0;
    endtask

    task automatic release_pulse();
        rel_req = 1'b1;
        tick();
        rel_req = 1'b0;
    endtask

    task automatic peek(input logic [LINE_W-1:0] l, input logic [WIDX_W-1:0] w,
                        output logic d);
        rd_line = l; rd_word = w;
        #1;
        d = rd_dirty;
    endtask

    task automatic drain_all(input string req);
        bit seen = 0;
        fl_ready = 1'b1;
        release_pulse();
        for (int k = 0; k < 40 && !seen; k++) begin
            if (rel_done) seen = 1;
            else tick();
        end
        chk(req, "drain reaches rel_done", 64'(seen), 64'd1);
        tick();
        fl_ready = 1'b0;
    endtask

    task automatic t_reset();
        logic d;
        chk("R6", "stall after reset", 64'(stall), 64'd0);
        chk("R9", "fl_valid after reset", 64'(fl_valid), 64'd0);
        chk("R8", "rel_done after reset", 64'(rel_done), 64'd0);
        peek(26'h100, 3'd0, d);
        chk("R7", "rd_dirty after reset", 64'(d), 64'd0);
    endtask

    task automatic t_update_threshold();
        logic d;
        upd_mode = 1'b1; fl_ready = 1'b0;
        store(26'h100, 3'd3);
        peek(26'h100, 3'd3, d); chk("R2", "new entry word3 dirty", 64'(d), 64'd1);
        peek(26'h100, 3'd2, d); chk("R7", "clean word2 not dirty", 64'(d), 64'd0);
        store(26'h100, 3'd5);
        peek(26'h100, 3'd5, d); chk("R3", "merged word5 dirty", 64'(d), 64'd1);
        peek(26'h100, 3'd3, d); chk("R3", "word3 kept after merge", 64'(d), 64'd1);
        chk("R11", "one entry no flush", 64'(fl_valid), 64'd0);
        store(26'h101, 3'd0);
        store(26'h102, 3'd1);
        store(26'h103, 3'd2);
        chk("R11", "four entries no flush", 64'(fl_valid), 64'd0);
        store(26'h104, 3'd4);
        chk("R4", "five entries flush offered", 64'(fl_valid), 64'd1);
        chk("R9", "oldest line offered", 64'(fl_line), 64'h100);
        chk("R3", "mask bits 3 and 5", 64'(fl_mask), 64'h28);
        tick();
        chk("R9", "line held without ready", 64'(fl_line), 64'h100);
        fl_ready = 1'b1;
        tick();
        fl_ready = 1'b0;
        chk("R4", "back to four entries", 64'(fl_valid), 64'd0);
        peek(26'h100, 3'd3, d); chk("R9", "flushed line freed", 64'(d), 64'd0);
    endtask

    task automatic t_swap();
        logic d;
        store(26'h105, 3'd6);
        chk("R4", "five again flush offered", 64'(fl_valid), 64'd1);
        chk("R9", "head is next oldest", 64'(fl_line), 64'h101);
        fl_ready = 1'b1;
        st_valid = 1'b1; st_line = 26'h106; st_word = 3'd7;
        tick();
        st_valid = 1'b0; fl_ready = 1'b0;
        chk("R10", "occupancy kept on swap", 64'(fl_valid), 64'd1);
        chk("R10", "head advanced on swap", 64'(fl_line), 64'h102);
        peek(26'h106, 3'd7, d); chk("R10", "new line tracked on swap", 64'(d), 64'd1);
        fl_ready = 1'b1;
        st_valid = 1'b1; st_line = 26'h102; st_word = 3'd0;
        tick();
        st_valid = 1'b0; fl_ready = 1'b0;
        chk("R10", "store to popped line keeps count", 64'(fl_valid), 64'd1);
        chk("R10", "head after popped-line store", 64'(fl_line), 64'h103);
        peek(26'h102, 3'd0, d); chk("R10", "popped line reopened", 64'(d), 64'd1);
        peek(26'h102, 3'd1, d); chk("R10", "reopened mask is fresh", 64'(d), 64'd0);
    endtask

    task automatic t_release_update();
        logic [LINE_W-1:0] order [5] = '{26'h103, 26'h104, 26'h105, 26'h106, 26'h102};
        int  n = 0;
        bit  seen = 0;
        release_pulse();
        chk("R6", "stall during release", 64'(stall), 64'd1);
        chk("R8", "no done before drain", 64'(rel_done), 64'd0);
        fl_ready = 1'b1;
        for (int k = 0; k < 20 && !seen; k++) begin
            if (rel_done) begin
                seen = 1;
            end else begin
                if (fl_valid) begin
                    if (n < 5) chk("R9", "release flush order", 64'(fl_line), 64'(order[n]));
                    n++;
                end
                tick();
            end
        end
        chk("R8", "release drained every entry", 64'(n), 64'd5);
        chk("R8", "rel_done seen", 64'(seen), 64'd1);
        chk("R6", "stall drops when empty", 64'(stall), 64'd0);
        tick();
        chk("R8", "rel_done lasts one cycle", 64'(rel_done), 64'd0);
        fl_ready = 1'b0;
    endtask

    task automatic t_full();
        logic d;
        upd_mode = 1'b1; fl_ready = 1'b0;
        for (int k = 0; k < 8; k++) store(26'h200 + LINE_W'(k), WIDX_W'(k));
        chk("R1", "stall when full", 64'(stall), 64'd1);
        store(26'h300, 3'd0);
        peek(26'h300, 3'd0, d); chk("R1", "store refused when full", 64'(d), 64'd0);
        store(26'h200, 3'd7);
        peek(26'h200, 3'd7, d); chk("R3", "merge accepted when full", 64'(d), 64'd1);
        chk("R9", "full head line", 64'(fl_line), 64'h200);
        chk("R3", "full head mask", 64'(fl_mask), 64'h81);
        drain_all("R8");
        chk("R6", "stall clear after drain", 64'(stall), 64'd0);
    endtask

    task automatic t_inval();
        upd_mode = 1'b0; fl_ready = 1'b1;
        store(26'h400, 3'd1);
        store(26'h401, 3'd2);
        chk("R5", "no flush without grant", 64'(fl_valid), 64'd0);
        chk("R6", "no stall while awaiting grant", 64'(stall), 64'd0);
        grant(26'h401);
        chk("R9", "younger grant waits behind head", 64'(fl_valid), 64'd0);
        grant(26'h400);
        chk("R5", "granted head offered", 64'(fl_valid), 64'd1);
        chk("R5", "granted head line", 64'(fl_line), 64'h400);
        tick();
        chk("R9", "next granted entry offered", 64'(fl_valid), 64'd1);
        chk("R9", "next granted line", 64'(fl_line), 64'h401);
        tick();
        chk("R9", "empty after retire", 64'(fl_valid), 64'd0);
        st_valid = 1'b1; st_line = 26'h402; st_word = 3'd4;
        grant_valid = 1'b1; grant_line = 26'h402;
        tick();
        st_valid = 1'b0; grant_valid = 1'b0;
        chk("R5", "grant with allocation", 64'(fl_valid), 64'd1);
        chk("R5", "grant with allocation line", 64'(fl_line), 64'h402);
        tick();
        chk("R5", "empty after same-cycle grant", 64'(fl_valid), 64'd0);
        fl_ready = 1'b0;
    endtask

    task automatic t_inval_release();
        upd_mode = 1'b0; fl_ready = 1'b1;
        store(26'h500, 3'd2);
        release_pulse();
        tick(); tick(); tick();
        chk("R6", "release stalls on ungranted entry", 64'(stall), 64'd1);
        chk("R8", "release waits for grant", 64'(rel_done), 64'd0);
        chk("R5", "ungranted not flushed at release", 64'(fl_valid), 64'd0);
        grant(26'h500);
        chk("R5", "granted entry flushed at release", 64'(fl_valid), 64'd1);
        tick();
        chk("R8", "release done after grant", 64'(rel_done), 64'd1);
        chk("R6", "stall released", 64'(stall), 64'd0);
        tick();
        fl_ready = 1'b0;
    endtask

    task automatic t_release_empty();
        release_pulse();
        chk("R8", "empty release done at once", 64'(rel_done), 64'd1);
        chk("R6", "no stall on empty release", 64'(stall), 64'd0);
        tick();
        chk("R8", "empty release pulse ends", 64'(rel_done), 64'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        tick();
        t_reset();
        t_update_threshold();
        t_swap();
        t_release_update();
        t_full();
        t_inval();
        t_inval_release();
        t_release_empty();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule